// File: doc/BRIEF.md
# Audio Sample-Rate Tick Generator

This block turns one base enable, a single-cycle pulse arriving at 1,411,200 Hz, into sample-rate strobes for three audio channels: two playback channels and one record channel. The first playback channel runs at one of four fixed rates, picked by a 2-bit select in a 32-bit control word. The second playback channel and the record channel share one programmable divider. It yields one strobe every (divider + 2) base enables, so the shared rate is 1,411,200 / (divider + 2) samples per second. Software picks the divider for a target rate R as ((1,411,200 + R/2) / R) - 2, using integer division. For 44,100 this gives 30.

The control word is written through a plain write strobe and held inside the block. Each channel has its own enable bit. A disabled channel makes no strobes, and its counter is held at zero. When a write alters the rate select or the divider, the block gives a one-cycle rate-changed pulse and restarts the counter whose rate was altered. The other counter keeps its phase.

Control word fields: bits 13:12 are the fixed-rate select (0 = 5512, 1 = 11025, 2 = 22050, 3 = 44100 samples per second). Bits 28:16 are the 13-bit shared divider. Bit 6 enables playback 1, bit 5 enables playback 2, and bit 4 enables record. All other bits are stored and have no effect.

Top module: `rate_tick_gen`

## Requirements
- R1: After reset the control word is zero, every strobe output and `rate_chg` are low, and no strobe appears until a channel is enabled.
- R2: With bit 6 set, `pb1_tick` pulses once every 256, 128, 64 or 32 base enables for select values 0, 1, 2 and 3 in bits 13:12.
- R3: With bit 5 set, `pb2_tick` pulses once every (D + 2) base enables, where D is bits 28:16. D = 30 gives one pulse per 32 base enables.
- R4: A channel whose enable bit (6, 5 or 4) is clear gives no strobes, and its counter restarts from zero when the channel is enabled again.
- R5: Playback 2 and record share one counter. While both bits 5 and 4 are set, `rec_tick` and `pb2_tick` pulse in the same cycles.
- R6: `rate_chg` is high for exactly one cycle, the cycle after a write that alters bits 13:12 or bits 28:16. A write that leaves both fields unchanged gives no pulse.
- R7: A write that alters bits 13:12 restarts the playback-1 counter from zero. A write that alters only bits 28:16 leaves the playback-1 count running.
- R8: Each strobe rises in the cycle after the base enable that completes its period. Cycles without a base enable leave all counts unchanged, so a sparse enable pattern gives the same strobe count per base enable.
- R9: The largest divider, 8191, gives one strobe per 8193 base enables.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_en | input | 1 | Single-cycle base enable at the 1,411,200 Hz rate |
| cfg_we | input | 1 | Control word write strobe |
| cfg_data | input | 32 | Control word written when `cfg_we` is high |
| pb1_tick | output | 1 | Playback-1 sample strobe |
| pb2_tick | output | 1 | Playback-2 sample strobe |
| rec_tick | output | 1 | Record sample strobe |
| rate_chg | output | 1 | One-cycle pulse after a write that altered a rate field |

## Verification
The assertions assume that `base_en` is a strobe and that its rising edges need no alignment with writes. They do not assume that writes are spaced apart, so no check relies on `rate_chg` being isolated. The stimulus never drives `base_en` in a write cycle. It separates writes by at least one idle cycle, so the count of rate-change pulses matches the count of altering writes. The enable patterns are dense, every third cycle, and every second cycle, so the held-count behaviour is tested against the same expected strobe counts.

// File: rtl/tickgen_pkg.sv
package tickgen_pkg;
  localparam int CTRL_W      = 32;
  localparam int SEL_LSB     = 12;
  localparam int SEL_W       = 2;
  localparam int DIV_LSB     = 16;
  localparam int DIV_W       = 13;
  localparam int EN_PB1      = 6;
  localparam int EN_PB2      = 5;
  localparam int EN_REC      = 4;
  localparam int FIX_LOG_MAX = 8;              // slowest fixed rate: 2**8 enables
  localparam int FIX_CNT_W   = FIX_LOG_MAX;
  localparam int SHR_CNT_W   = DIV_W + 1;      // holds divider + 1

  // last count value of the fixed-rate divider for a given select
  function automatic logic [FIX_CNT_W-1:0] fixed_last(input logic [SEL_W-1:0] sel);
    logic [FIX_CNT_W:0] period;
    period = (FIX_CNT_W+1)'(1) << (FIX_LOG_MAX - int'(sel));
    return FIX_CNT_W'(period - 1'b1);
  endfunction
endpackage

// File: rtl/tick_divider.sv
module tick_divider #(
  parameter int CNT_W = 8,
  parameter int NOUT  = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             base_en,
  input  logic             restart,
  input  logic [CNT_W-1:0] last,
  input  logic [NOUT-1:0]  out_en,
  output logic [NOUT-1:0]  tick
);
  logic [CNT_W-1:0] cnt_q;
  logic             run;
  logic             wrap;

  assign run  = |out_en;
  assign wrap = run && base_en && !restart && (cnt_q == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (restart || !run) begin
      cnt_q <= '0;
    end else if (base_en) begin
      cnt_q <= wrap ? '0 : cnt_q + 1'b1;
    end
  end

  for (genvar g = 0; g < NOUT; g++) begin : g_out
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tick[g] <= 1'b0;
      else        tick[g] <= wrap && out_en[g];
    end
  end
endmodule

// File: rtl/rate_field_watch.sv
module rate_field_watch
  import tickgen_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [CTRL_W-1:0] wdata,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic              sel_new,
  output logic              div_new,
  output logic              chg_pulse
);
  logic [SEL_W-1:0] sel_cur, sel_in;
  logic [DIV_W-1:0] div_cur, div_in;

  assign sel_cur = ctrl_q[SEL_LSB +: SEL_W];
  assign sel_in  = wdata[SEL_LSB +: SEL_W];
  assign div_cur = ctrl_q[DIV_LSB +: DIV_W];
  assign div_in  = wdata[DIV_LSB +: DIV_W];

  assign sel_new = we && (sel_in != sel_cur);
  assign div_new = we && (div_in != div_cur);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      chg_pulse <= 1'b0;
    end else begin
      chg_pulse <= sel_new || div_new;
      if (we) ctrl_q <= wdata;
    end
  end
endmodule

// File: rtl/rate_tick_gen.sv
module rate_tick_gen
  import tickgen_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              base_en,
  input  logic              cfg_we,
  input  logic [CTRL_W-1:0] cfg_data,
  output logic              pb1_tick,
  output logic              pb2_tick,
  output logic              rec_tick,
  output logic              rate_chg
);
  logic [CTRL_W-1:0]    ctrl_q;
  logic                 sel_new, div_new;
  logic [FIX_CNT_W-1:0] fix_last;
  logic [SHR_CNT_W-1:0] shr_last;
  logic [1:0]           shr_en, shr_tick;

  rate_field_watch u_watch (
    .clk       (clk),
    .rst_n     (rst_n),
    .we        (cfg_we),
    .wdata     (cfg_data),
    .ctrl_q    (ctrl_q),
    .sel_new   (sel_new),
    .div_new   (div_new),
    .chg_pulse (rate_chg)
  );

  assign fix_last = fixed_last(ctrl_q[SEL_LSB +: SEL_W]);
  assign shr_last = SHR_CNT_W'(ctrl_q[DIV_LSB +: DIV_W]) + 1'b1;
  assign shr_en   = {ctrl_q[EN_REC], ctrl_q[EN_PB2]};

  tick_divider #(.CNT_W(FIX_CNT_W), .NOUT(1)) u_fixed (
    .clk     (clk),
    .rst_n   (rst_n),
    .base_en (base_en),
    .restart (sel_new),
    .last    (fix_last),
    .out_en  (ctrl_q[EN_PB1]),
    .tick    (pb1_tick)
  );

  tick_divider #(.CNT_W(SHR_CNT_W), .NOUT(2)) u_shared (
    .clk     (clk),
    .rst_n   (rst_n),
    .base_en (base_en),
    .restart (div_new),
    .last    (shr_last),
    .out_en  (shr_en),
    .tick    (shr_tick)
  );

  assign pb2_tick = shr_tick[0];
  assign rec_tick = shr_tick[1];
endmodule

// File: rtl/tickgen_checker.sv
module tickgen_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        base_en,
  input logic        cfg_we,
  input logic [31:0] ctrl_q,
  input logic        pb1_tick,
  input logic        pb2_tick,
  input logic        rec_tick,
  input logic        rate_chg
);
  p_tick_after_base_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pb1_tick || pb2_tick || rec_tick) |-> $past(base_en));
  p_chg_after_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rate_chg |-> $past(cfg_we));
  p_pb1_enabled_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pb1_tick |-> $past(ctrl_q[6]));
  p_pb2_enabled_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pb2_tick |-> $past(ctrl_q[5]));
  p_rec_enabled_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rec_tick |-> $past(ctrl_q[4]));
  p_shared_phase_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pb2_tick && $past(ctrl_q[4])) |-> rec_tick);
  p_pb1_spacing_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pb1_tick |=> !pb1_tick);
  p_pb2_spacing_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pb2_tick |=> !pb2_tick);
endmodule

bind rate_tick_gen tickgen_checker u_tickgen_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .base_en  (base_en),
  .cfg_we   (cfg_we),
  .ctrl_q   (ctrl_q),
  .pb1_tick (pb1_tick),
  .pb2_tick (pb2_tick),
  .rec_tick (rec_tick),
  .rate_chg (rate_chg)
);

// File: tb/test_rate_tick_gen.sv
module test_rate_tick_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        base_en = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_data = '0;
  logic        pb1_tick, pb2_tick, rec_tick, rate_chg;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 0;

  // behavioural reference state
  int  m_ctrl = 0;
  int  m_c1 = 0;
  int  m_c2 = 0;
  bit  e1 = 0, e2 = 0, e3 = 0, ech = 0;
  int  n1 = 0, n2 = 0, n3 = 0, nch = 0;

  always #5 clk = ~clk;

  rate_tick_gen i_rate_tick_gen (
    .clk(clk), .rst_n(rst_n), .base_en(base_en), .cfg_we(cfg_we),
    .cfg_data(cfg_data), .pb1_tick(pb1_tick), .pb2_tick(pb2_tick),
    .rec_tick(rec_tick), .rate_chg(rate_chg)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // reference model: periods from the requirement formulas
  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctrl = 0; m_c1 = 0; m_c2 = 0;
      e1 = 0; e2 = 0; e3 = 0; ech = 0;
    end else begin
      int sel, dv, p1, p2, nsel, ndv;
      bit r1, r2, wrap;
      sel  = (m_ctrl >> 12) & 3;
      dv   = (m_ctrl >> 16) & 8191;
      nsel = (int'(cfg_data) >> 12) & 3;
      ndv  = (int'(cfg_data) >> 16) & 8191;
      p1   = 256 >> sel;
      p2   = dv + 2;
      r1   = cfg_we && (nsel != sel);
      r2   = cfg_we && (ndv != dv);
      ech  = r1 || r2;
      e1 = 0;
      if (r1 || !m_ctrl[6]) m_c1 = 0;
      else if (base_en) begin
        if (m_c1 == p1 - 1) begin m_c1 = 0; e1 = 1; end
        else m_c1++;
      end
      wrap = 0;
      if (r2 || !(m_ctrl[5] || m_ctrl[4])) m_c2 = 0;
      else if (base_en) begin
        if (m_c2 == p2 - 1) begin m_c2 = 0; wrap = 1; end
        else m_c2++;
      end
      e2 = wrap && m_ctrl[5];
      e3 = wrap && m_ctrl[4];
      if (cfg_we) m_ctrl = int'(cfg_data);
    end
  end

  // every-cycle comparison and strobe counting, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2", "pb1_tick vs model", int'(pb1_tick), int'(e1));
      chk("R3", "pb2_tick vs model", int'(pb2_tick), int'(e2));
      chk("R5", "rec_tick vs model", int'(rec_tick), int'(e3));
      chk("R6", "rate_chg vs model", int'(rate_chg), int'(ech));
      n1 += int'(pb1_tick); n2 += int'(pb2_tick);
      n3 += int'(rec_tick); nch += int'(rate_chg);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=<150000 cycles", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic wr(input int data);
    step(); base_en = 1'b0; cfg_we = 1'b1; cfg_data = 32'(data);
    step(); cfg_we = 1'b0;
    step();
  endtask

  task automatic run(input int pulses, input int gap);
    for (int i = 0; i < pulses; i++) begin
      step(); base_en = 1'b1;
      for (int g = 1; g < gap; g++) begin step(); base_en = 1'b0; end
    end
    step(); base_en = 1'b0;
    for (int i = 0; i < 3; i++) step();
  endtask

  int s1, s2, s3, sc;
  task automatic snap();
    s1 = n1; s2 = n2; s3 = n3; sc = nch;
  endtask

  initial begin
    for (int i = 0; i < 4; i++) step();
    chk("R1", "pb1_tick in reset", int'(pb1_tick), 0);
    chk("R1", "rate_chg in reset", int'(rate_chg), 0);
    rst_n = 1'b1;
    step();
    chk("R1", "pb2_tick after reset", int'(pb2_tick), 0);
    snap(); run(300, 1);
    chk("R1", "strobes with reset control", (n1 - s1) + (n2 - s2) + (n3 - s3), 0);

    // R2: each fixed select over 512 base enables
    for (int sel = 0; sel < 4; sel++) begin
      wr(0); wr((sel << 12) | (1 << 6));
      snap(); run(512, 1);
      chk("R2", $sformatf("pb1 strobes sel=%0d", sel), n1 - s1, 2 << sel);
    end

    // R8: sparse enables give the same count per enable
    wr(0); wr((3 << 12) | (1 << 6));
    snap(); run(96, 3);
    chk("R8", "pb1 strobes gap 3", n1 - s1, 3);

    // R3, R5, R4: shared divider 5 -> period 7, both shared channels on
    wr(0); wr((5 << 16) | (1 << 5) | (1 << 4));
    snap(); run(70, 1);
    chk("R3", "pb2 strobes div=5", n2 - s2, 10);
    chk("R5", "rec strobes div=5", n3 - s3, 10);
    chk("R4", "pb1 disabled strobes", n1 - s1, 0);

    // R3/R4: divider 30 for 44100, record disabled
    wr(0); wr((30 << 16) | (1 << 5));
    snap(); run(64, 2);
    chk("R3", "pb2 strobes div=30", n2 - s2, 2);
    chk("R4", "rec disabled strobes", n3 - s3, 0);

    // R6: change pulses only for rate field edits
    wr(0);
    snap(); wr((1 << 6) | (1 << 5));
    chk("R6", "pulse on enable-only write", nch - sc, 0);
    snap(); wr((2 << 12) | (1 << 6) | (1 << 5));
    chk("R6", "pulse on select write", nch - sc, 1);
    snap(); wr((2 << 12) | (7 << 16) | (1 << 6) | (1 << 5));
    chk("R6", "pulse on divider write", nch - sc, 1);
    snap(); wr((2 << 12) | (7 << 16) | (1 << 6) | (1 << 5));
    chk("R6", "pulse on repeated write", nch - sc, 0);

    // R7: divider edit keeps pb1 phase, select edit restarts it
    wr(0); wr((3 << 12) | (1 << 6));
    run(20, 1);
    wr((3 << 12) | (9 << 16) | (1 << 6));
    snap(); run(12, 1);
    chk("R7", "pb1 phase kept across divider edit", n1 - s1, 1);
    wr((2 << 12) | (9 << 16) | (1 << 6));
    snap(); run(63, 1);
    chk("R7", "pb1 restarted after select edit", n1 - s1, 0);
    snap(); run(1, 1);
    chk("R7", "pb1 first strobe after restart", n1 - s1, 1);

    // R4: re-enable restarts from zero
    wr((2 << 12)); wr((2 << 12) | (1 << 6));
    snap(); run(63, 2);
    chk("R4", "pb1 restart after re-enable", n1 - s1, 0);

    // R9: largest divider
    wr(0); wr((8191 << 16) | (1 << 5));
    snap(); run(8192, 1);
    chk("R9", "pb2 strobes before 8193", n2 - s2, 0);
    snap(); run(1, 1);
    chk("R9", "pb2 strobe at 8193", n2 - s2, 1);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule